// File: doc/BRIEF.md
# Node Failure Detection Status Unit

This unit sits in a switch that joins a set of compute nodes sharing memory. For each node it runs a response timer that counts the cycles during which a request to that node is outstanding and no reply has come back. When that count passes a programmable limit, the node is treated as dead under a fail-stop model, and its viral status bit is set. The bit stays set until software clears it once recovery has finished.

A newly set viral bit starts a report. The unit latches the failed node's index, chooses the lowest-numbered node that is still alive to act as configuration manager, sends that node a one-cycle interrupt pulse, and raises a halt request. The halt request stays high until the manager acknowledges that the failed node has been disabled. Failures that occur while a report is open are recorded in their viral bits only. Each one is reported in turn, lowest index first, after the open report has been acknowledged.

Top module: `nfd_status_unit`

## Requirements
- R1: After reset, all viral bits, the interrupt, the halt request, the failed-node index and the manager index read 0.
- R2: A node whose request input is high and whose response input is low on consecutive rising edges has its viral bit read 0 after T+1 such edges and 1 after T+2, where T is the timeout input value.
- R3: A response pulse, or a low request input, resets that node's timer to zero, so a node that replies at least once in every T+1 pending cycles never goes viral.
- R4: A viral bit is sticky: it stays 1 when the request input drops, and nothing except a software clear resets it.
- R5: Driving a node's clear input high for one edge resets its viral bit and its timer.
- R6: On the edge after a viral bit becomes 1 with no report open, the interrupt output is high for exactly one cycle, the failed-node index equals that node's number, and the halt request goes high in the same cycle.
- R7: The manager index sent with the interrupt is the lowest node number whose viral bit reads 0 in that cycle; if every viral bit is 1, no interrupt is sent, but the halt request is still raised.
- R8: The halt request stays high until an acknowledge is seen and drops on the edge that samples it; an acknowledge while no report is open has no effect.
- R9: A node that fails while a report is open gets its viral bit set but raises no interrupt; its report is sent on the second edge after the acknowledge of the open report.
- R10: When several nodes fail on the same edge, they are reported one per acknowledge, in ascending node order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pend_i | input | NODES | Per node: a request to the node is outstanding |
| resp_i | input | NODES | Per node: a response arrived this cycle |
| timeout_i | input | CNT_W | Pending-cycle limit T before a node is declared dead |
| viral_clr_i | input | NODES | Per node: software clear of the viral bit |
| mgr_ack_i | input | 1 | Manager confirms the failed node is disabled |
| viral_o | output | NODES | Sticky viral status bits |
| irq_o | output | 1 | One-cycle interrupt toward the manager |
| irq_dest_o | output | ID_W | Node number of the chosen manager |
| fail_id_o | output | ID_W | Node number of the failure being reported |
| halt_o | output | 1 | Halt request held until acknowledge |

## Verification
Single failures are driven with random timeouts and nodes, and each is optionally preceded by an earlier failure. This separates an off-by-one in the timer from an error in choosing the manager. Periodic replies and short request drops that stay just inside the limit show whether the timer resets correctly. Two failures on one edge, a failure during an open report, and a run in which every node fails in turn test report ordering, the deferral of reports while one is open, and the case with no survivor.

// File: rtl/nfd_pkg.sv
package nfd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HALT = 1'b1
  } nfd_state_e;
endpackage

// File: rtl/nfd_resp_timer.sv
module nfd_resp_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_i,
  input  logic             resp_i,
  input  logic             clr_i,
  input  logic             dead_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             idle_w;

  assign idle_w = !pend_i || resp_i || clr_i;

  always_comb begin
    if (idle_w)
      cnt_d = '0;
    else if (cnt_q != CNT_MAX)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign fire_o = !idle_w && !dead_i && (cnt_q > limit_i);
endmodule

// File: rtl/nfd_viral_bank.sv
module nfd_viral_bank #(
  parameter int NODES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] fire_i,
  input  logic [NODES-1:0] clr_i,
  input  logic [NODES-1:0] rep_set_i,
  output logic [NODES-1:0] viral_q_o,
  output logic [NODES-1:0] viral_d_o,
  output logic [NODES-1:0] rep_q_o
);
  logic [NODES-1:0] viral_q, viral_d;
  logic [NODES-1:0] rep_q, rep_d;
  logic             viral_en, rep_en;

  always_comb begin
    viral_d  = (viral_q & ~clr_i) | fire_i;
    rep_d    = (rep_q & ~clr_i) | rep_set_i;
    viral_en = (viral_d != viral_q);
    rep_en   = (rep_d != rep_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viral_q <= '0;
      rep_q   <= '0;
    end else begin
      if (viral_en) viral_q <= viral_d;
      if (rep_en)   rep_q   <= rep_d;
    end
  end

  assign viral_q_o = viral_q;
  assign viral_d_o = viral_d;
  assign rep_q_o   = rep_q;
endmodule

// File: rtl/nfd_ctrl.sv
module nfd_ctrl
  import nfd_pkg::*;
#(
  parameter int NODES = 8,
  parameter int ID_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] viral_q_i,
  input  logic [NODES-1:0] viral_d_i,
  input  logic [NODES-1:0] rep_q_i,
  input  logic             ack_i,
  output logic [NODES-1:0] rep_set_o,
  output logic             irq_o,
  output logic             halt_o,
  output logic [ID_W-1:0]  fail_id_o,
  output logic [ID_W-1:0]  dest_o
);
  nfd_state_e       state_q, state_d;
  logic             irq_q, irq_d;
  logic [ID_W-1:0]  fail_q, fail_d;
  logic [ID_W-1:0]  dest_q, dest_d;
  logic             id_en;

  logic [NODES-1:0] unrep_w;
  logic [ID_W-1:0]  pick_idx;
  logic             pick_any;
  logic [ID_W-1:0]  mgr_idx;
  logic             mgr_any;

  assign unrep_w = viral_q_i & ~rep_q_i;

  // lowest unreported failure (downward scan, lowest index wins)
  always_comb begin
    pick_idx = '0;
    pick_any = 1'b0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (unrep_w[i]) begin
        pick_idx = ID_W'(i);
        pick_any = 1'b1;
      end
    end
  end

  // lowest surviving node, judged on the viral state after this edge
  always_comb begin
    mgr_idx = '0;
    mgr_any = 1'b0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (!viral_d_i[i]) begin
        mgr_idx = ID_W'(i);
        mgr_any = 1'b1;
      end
    end
  end

  always_comb begin
    state_d   = state_q;
    irq_d     = 1'b0;
    fail_d    = fail_q;
    dest_d    = dest_q;
    rep_set_o = '0;
    case (state_q)
      ST_IDLE: begin
        if (pick_any) begin
          state_d             = ST_HALT;
          rep_set_o[pick_idx] = 1'b1;
          fail_d              = pick_idx;
          irq_d               = mgr_any;
          if (mgr_any) dest_d = mgr_idx;
        end
      end
      ST_HALT: begin
        if (ack_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    id_en = (state_q == ST_IDLE) && pick_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
      fail_q  <= '0;
      dest_q  <= '0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      if (id_en) begin
        fail_q <= fail_d;
        dest_q <= dest_d;
      end
    end
  end

  assign irq_o     = irq_q;
  assign halt_o    = (state_q == ST_HALT);
  assign fail_id_o = fail_q;
  assign dest_o    = dest_q;
endmodule

// File: rtl/nfd_status_unit.sv
module nfd_status_unit #(
  parameter int NODES = 8,
  parameter int CNT_W = 16,
  localparam int ID_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] req_pend_i,
  input  logic [NODES-1:0] resp_i,
  input  logic [CNT_W-1:0] timeout_i,
  input  logic [NODES-1:0] viral_clr_i,
  input  logic             mgr_ack_i,
  output logic [NODES-1:0] viral_o,
  output logic             irq_o,
  output logic [ID_W-1:0]  irq_dest_o,
  output logic [ID_W-1:0]  fail_id_o,
  output logic             halt_o
);
  logic [NODES-1:0] fire_w;
  logic [NODES-1:0] viral_q_w, viral_d_w, rep_q_w, rep_set_w;

  for (genvar n = 0; n < NODES; n++) begin : g_timer
    nfd_resp_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_i  (req_pend_i[n]),
      .resp_i  (resp_i[n]),
      .clr_i   (viral_clr_i[n]),
      .dead_i  (viral_q_w[n]),
      .limit_i (timeout_i),
      .fire_o  (fire_w[n])
    );
  end

  nfd_viral_bank #(.NODES(NODES)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire_w),
    .clr_i     (viral_clr_i),
    .rep_set_i (rep_set_w),
    .viral_q_o (viral_q_w),
    .viral_d_o (viral_d_w),
    .rep_q_o   (rep_q_w)
  );

  nfd_ctrl #(.NODES(NODES), .ID_W(ID_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .viral_q_i (viral_q_w),
    .viral_d_i (viral_d_w),
    .rep_q_i   (rep_q_w),
    .ack_i     (mgr_ack_i),
    .rep_set_o (rep_set_w),
    .irq_o     (irq_o),
    .halt_o    (halt_o),
    .fail_id_o (fail_id_o),
    .dest_o    (irq_dest_o)
  );

  assign viral_o = viral_q_w;
endmodule

// File: rtl/nfd_status_unit_chk.sv
module nfd_status_unit_chk #(
  parameter int NODES = 8,
  parameter int ID_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NODES-1:0] viral_clr_i,
  input logic             mgr_ack_i,
  input logic [NODES-1:0] viral_o,
  input logic             irq_o,
  input logic [ID_W-1:0]  irq_dest_o,
  input logic             halt_o
);
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_irq_with_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> halt_o);

  p_mgr_alive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !viral_o[irq_dest_o]);

  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !mgr_ack_i) |=> halt_o);

  p_ack_drops_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && mgr_ack_i) |=> !halt_o);

  p_no_irq_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !mgr_ack_i) |=> !irq_o);

  p_viral_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(viral_o & ~viral_clr_i)) |=>
      ((viral_o & $past(viral_o & ~viral_clr_i)) == $past(viral_o & ~viral_clr_i)));
endmodule

bind nfd_status_unit nfd_status_unit_chk #(.NODES(NODES), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .viral_clr_i (viral_clr_i),
  .mgr_ack_i   (mgr_ack_i),
  .viral_o     (viral_o),
  .irq_o       (irq_o),
  .irq_dest_o  (irq_dest_o),
  .halt_o      (halt_o)
);

// File: tb/tb_nfd_status_unit.sv
module tb_nfd_status_unit;
  localparam int NODES = 8;
  localparam int CNT_W = 16;
  localparam int ID_W  = 3;

  logic             clk;
  logic             rst_n;
  logic [NODES-1:0] req_pend_i, resp_i, viral_clr_i;
  logic [CNT_W-1:0] timeout_i;
  logic             mgr_ack_i;
  logic [NODES-1:0] viral_o;
  logic             irq_o, halt_o;
  logic [ID_W-1:0]  irq_dest_o, fail_id_o;

  int compared   = 0;
  int mismatched = 0;
  logic [NODES-1:0] exp_viral;
  bit done = 0;

  nfd_status_unit #(.NODES(NODES), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_pend_i(req_pend_i), .resp_i(resp_i),
    .timeout_i(timeout_i), .viral_clr_i(viral_clr_i), .mgr_ack_i(mgr_ack_i),
    .viral_o(viral_o), .irq_o(irq_o), .irq_dest_o(irq_dest_o),
    .fail_id_o(fail_id_o), .halt_o(halt_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int lowest_alive(logic [NODES-1:0] v);
    for (int i = 0; i < NODES; i++) if (!v[i]) return i;
    return -1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // start a failure of node n with limit t and check up to the report
  task automatic raise_fail(int n, int t);
    int mgr;
    timeout_i     = CNT_W'(t);
    req_pend_i[n] = 1'b1;
    repeat (t + 1) @(posedge clk);
    @(negedge clk);
    chk("R2", "viral before limit", int'(viral_o[n]), 0);
    tick();
    chk("R2", "viral after limit", int'(viral_o[n]), 1);
    exp_viral[n] = 1'b1;
    mgr = lowest_alive(exp_viral);
    tick();
    chk("R6", "halt raised", int'(halt_o), 1);
    chk("R6", "fail id", int'(fail_id_o), n);
    if (mgr >= 0) begin
      chk("R6", "irq pulse", int'(irq_o), 1);
      chk("R7", "manager id", int'(irq_dest_o), mgr);
    end else begin
      chk("R7", "no survivor irq", int'(irq_o), 0);
    end
    req_pend_i[n] = 1'b0;
    tick();
    chk("R6", "irq one cycle", int'(irq_o), 0);
    chk("R8", "halt held", int'(halt_o), 1);
  endtask

  task automatic do_ack();
    mgr_ack_i = 1'b1;
    tick();
    mgr_ack_i = 1'b0;
    chk("R8", "halt dropped by ack", int'(halt_o), 0);
  endtask

  task automatic clear_all();
    viral_clr_i = '1;
    tick();
    viral_clr_i = '0;
    exp_viral   = '0;
    chk("R5", "viral cleared", int'(viral_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected done");
      summary();
    end
  end

  initial begin
    int seed = 1234;
    int n, m, t;
    void'($urandom(seed));
    rst_n = 1'b0; req_pend_i = '0; resp_i = '0; viral_clr_i = '0;
    timeout_i = '0; mgr_ack_i = 1'b0; exp_viral = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "viral", int'(viral_o), 0);
    chk("R1", "irq", int'(irq_o), 0);
    chk("R1", "halt", int'(halt_o), 0);
    chk("R1", "fail id", int'(fail_id_o), 0);
    chk("R1", "dest", int'(irq_dest_o), 0);

    // R2/R6/R7 directed single failure, then R4 sticky
    raise_fail(3, 4);
    repeat (4) tick();
    chk("R8", "halt without ack", int'(halt_o), 1);
    chk("R4", "viral sticky after req drop", int'(viral_o[3]), 1);
    do_ack();
    // R8 ack while idle ignored
    mgr_ack_i = 1'b1; tick(); mgr_ack_i = 1'b0; tick();
    chk("R8", "idle ack halt", int'(halt_o), 0);
    chk("R8", "idle ack irq", int'(irq_o), 0);
    chk("R4", "viral still set", int'(viral_o[3]), 1);
    // R5 single clear
    viral_clr_i[3] = 1'b1; tick(); viral_clr_i[3] = 1'b0;
    exp_viral[3] = 1'b0;
    chk("R5", "node 3 cleared", int'(viral_o[3]), 0);

    // R3 replies and request drops keep the timer below the limit
    timeout_i = CNT_W'(3);
    req_pend_i[2] = 1'b1;
    for (int k = 0; k < 6; k++) begin
      repeat (3) tick();
      resp_i[2] = 1'b1; tick(); resp_i[2] = 1'b0;
    end
    for (int k = 0; k < 4; k++) begin
      repeat (3) tick();
      req_pend_i[2] = 1'b0; tick(); req_pend_i[2] = 1'b1;
    end
    chk("R3", "no fail with replies", int'(viral_o[2]), 0);
    chk("R3", "no irq with replies", int'(irq_o | halt_o), 0);
    req_pend_i[2] = 1'b0; tick();

    // R7 manager skips failed nodes
    raise_fail(0, 2); do_ack();
    raise_fail(1, 1); do_ack();
    clear_all();

    // R9 failure while a report is open
    raise_fail(5, 2);
    req_pend_i[6] = 1'b1;
    repeat (4) tick();
    chk("R9", "second viral set", int'(viral_o[6]), 1);
    chk("R9", "no second irq", int'(irq_o), 0);
    exp_viral[6] = 1'b1;
    req_pend_i[6] = 1'b0;
    tick();
    chk("R9", "no late irq", int'(irq_o), 0);
    do_ack();
    chk("R9", "no irq at ack edge", int'(irq_o), 0);
    tick();
    chk("R9", "deferred irq", int'(irq_o), 1);
    chk("R9", "deferred fail id", fail_id_o, 6);
    chk("R9", "deferred manager", int'(irq_dest_o), 0);
    do_ack();
    clear_all();

    // R10 simultaneous failures, ascending order
    timeout_i = CNT_W'(1);
    req_pend_i[4] = 1'b1; req_pend_i[2] = 1'b1;
    repeat (3) tick();
    chk("R10", "both viral", int'(viral_o), 8'h14);
    tick();
    chk("R10", "first irq", int'(irq_o), 1);
    chk("R10", "first is lower", int'(fail_id_o), 2);
    req_pend_i = '0;
    tick();
    do_ack();
    tick();
    chk("R10", "second irq", int'(irq_o), 1);
    chk("R10", "second is higher", int'(fail_id_o), 4);
    chk("R10", "second manager", int'(irq_dest_o), 0);
    do_ack();
    clear_all();

    // random single and double failures
    for (int it = 0; it < 24; it++) begin
      n = $urandom % NODES;
      t = $urandom % 8;
      if ($urandom % 2) begin
        m = (n + 1 + ($urandom % (NODES - 1))) % NODES;
        raise_fail(m, $urandom % 5);
        do_ack();
      end
      raise_fail(n, t);
      do_ack();
      clear_all();
    end

    // R7 every node fails in turn; the last has no survivor
    for (int k = 0; k < NODES; k++) begin
      raise_fail(k, 0);
      do_ack();
    end
    chk("R7", "all viral", int'(viral_o), 8'hFF);
    clear_all();

    done = 1;
    summary();
  end
endmodule